// File: doc/BRIEF.md
# Counter-Mode Keystream Sequencer for CCM

This block drives the counter-mode half of a CCM engine. It forms each counter block from a flags byte, the nonce and a big-endian block counter. It hands the block to an external 128-bit block cipher through a one-cycle start pulse and a one-cycle done pulse. It XORs the returned keystream with the matching message block and presents the result as one output block with a one-cycle valid strobe. Because the same keystream serves both directions, the output is ciphertext when plaintext goes in and plaintext when ciphertext goes in.

Message blocks use counters 1, 2, 3, and so on, so the keystream can run alongside the authentication chain. The counter-zero keystream is never applied to message data. It is requested separately, after the authentication side has taken its last block. The block then holds that value on a dedicated output with a level valid flag, ready for encrypting the tag. A 2-bit command chooses between idling, counting through the message and producing the counter-zero keystream. The external message source supplies the block whose counter value appears in the issued counter block.

Top module: `ccm_ks_top`

## Requirements
- R1: After reset the outputs `ks_out_vld`, `s0_vld` and `ciph_start` are low and `ks_out` and `s0_out` are zero.
- R2: Every issued counter block has byte 0 (bits 127:120) equal to LEN_BYTES-1. The next 15-LEN_BYTES bytes carry the nonce. The last LEN_BYTES bytes carry the counter, most significant byte first.
- R3: Under command 2'b11 the block issues counter blocks with counter values 1, 2, 3, and so on, each one greater than the last. It issues a new block only after `ciph_done` has returned the previous one.
- R4: One cycle after `ciph_done` returns a message keystream block, `ks_out` equals the keystream XOR `msg_blk` for one cycle, with `ks_out_vld` high for that cycle only.
- R5: In the final block, when `msg_len` mod 16 = r is not 0, only the first r bytes (from bits 127:120 downward) of `ks_out` carry data. The remaining bytes are zero.
- R6: Counting stops after ceil(`msg_len`/16) blocks. With a length of zero, command 2'b11 issues nothing.
- R7: Command 2'b01 issues one counter block with counter 0. Its keystream appears on `s0_out` with `s0_vld` held high. It never raises `ks_out_vld`, and holding 2'b01 issues no second request.
- R8: Commands 2'b00 and 2'b10 issue no cipher request. They return the sequencer to its initial state: the next count starts again at counter 1 and `s0_vld` falls.
- R9: A command change while a cipher request is outstanding does not abort it. The outstanding result is still delivered.
- R10: `ciph_start` is a single-cycle pulse, and `ciph_blk` stays stable until `ciph_done` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd | input | 2 | 00/10 idle, 01 counter-zero keystream, 11 count through message |
| nonce | input | 8*(15-LEN_BYTES) | Nonce placed after the flags byte |
| msg_len | input | 8*LEN_BYTES | Message length in bytes |
| msg_blk | input | 128 | Message block matching the outstanding counter value, valid with `ciph_done` |
| ciph_start | output | 1 | One-cycle request to the block cipher |
| ciph_blk | output | 128 | Counter block for the cipher |
| ciph_done | input | 1 | One-cycle completion from the cipher |
| ciph_res | input | 128 | Keystream block returned with `ciph_done` |
| ks_out | output | 128 | Message block XOR keystream, final bytes masked |
| ks_out_vld | output | 1 | One-cycle strobe for `ks_out` |
| s0_out | output | 128 | Counter-zero keystream for the tag |
| s0_vld | output | 1 | Level flag, high while `s0_out` is held |

## Verification
The assertions assume a cipher that raises `ciph_done` exactly once for each `ciph_start`, after any latency of zero or more cycles and never unprompted. They also assume that `nonce` and `msg_len` change only while the command is idle and no request is outstanding. The bench's cipher model answers each request once, after a random delay of 0 to 3 cycles. The stimulus changes length and nonce only after an idle command has been held for several cycles. A scrambled function of the counter block stands in for the cipher, so the bench can predict every keystream value without a real cipher.

// File: rtl/ccm_ks_pkg.sv
package ccm_ks_pkg;
  localparam int BLK_W   = 128;
  localparam int BLK_BYT = BLK_W / 8;

  typedef enum logic [1:0] {
    CMD_HOLD_A = 2'b00,
    CMD_TAGKS  = 2'b01,
    CMD_HOLD_B = 2'b10,
    CMD_COUNT  = 2'b11
  } ks_cmd_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } sq_state_e;

  typedef enum logic {
    JOB_MSG = 1'b0,
    JOB_TAG = 1'b1
  } job_e;
endpackage

// File: rtl/ccm_ks_ablk.sv
module ccm_ks_ablk
  import ccm_ks_pkg::*;
#(
  parameter int LEN_BYTES = 2,
  localparam int CTR_W    = 8 * LEN_BYTES,
  localparam int NONCE_W  = 8 * (15 - LEN_BYTES)
) (
  input  logic [NONCE_W-1:0] nonce,
  input  logic [CTR_W-1:0]   ctr,
  output logic [BLK_W-1:0]   blk
);
  localparam logic [7:0] FLAGS = 8'(LEN_BYTES - 1);

  always_comb begin
    blk = {FLAGS, nonce, ctr};
  end
endmodule

// File: rtl/ccm_ks_mask.sv
module ccm_ks_mask
  import ccm_ks_pkg::*;
#(
  localparam int KEEP_W = $clog2(BLK_BYT + 1)
) (
  input  logic [BLK_W-1:0]  din,
  input  logic [KEEP_W-1:0] keep,
  output logic [BLK_W-1:0]  dout
);
  for (genvar g = 0; g < BLK_BYT; g++) begin : g_byte
    localparam logic [KEEP_W-1:0] IDX = KEEP_W'(g);
    always_comb begin
      dout[BLK_W-1-8*g -: 8] = (IDX < keep) ? din[BLK_W-1-8*g -: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/ccm_ks_seq.sv
module ccm_ks_seq
  import ccm_ks_pkg::*;
#(
  parameter int CTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [CTR_W-1:0] nblk,
  input  logic             ciph_done,
  output logic             start,
  output logic             busy,
  output logic             tag_job,
  output logic [CTR_W-1:0] ctr,
  output logic             last_blk,
  output logic             fin_msg,
  output logic             fin_tag,
  output logic             tag_have
);
  sq_state_e        st_q, st_d;
  job_e             job_q, job_d;
  logic [CTR_W-1:0] ctr_q, ctr_d;
  logic             have_q, have_d;
  logic             start_q, start_d;
  ks_cmd_e          cmd_e;

  assign cmd_e = ks_cmd_e'(cmd);

  always_comb begin
    st_d    = st_q;
    job_d   = job_q;
    ctr_d   = ctr_q;
    have_d  = have_q;
    start_d = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        unique case (cmd_e)
          CMD_COUNT: begin
            if (ctr_q <= nblk) begin
              start_d = 1'b1;
              job_d   = JOB_MSG;
              st_d    = SQ_WAIT;
            end
          end
          CMD_TAGKS: begin
            if (!have_q) begin
              start_d = 1'b1;
              job_d   = JOB_TAG;
              st_d    = SQ_WAIT;
            end
          end
          default: begin
            ctr_d  = CTR_W'(1);
            have_d = 1'b0;
          end
        endcase
      end
      SQ_WAIT: begin
        if (ciph_done) begin
          st_d = SQ_IDLE;
          if (job_q == JOB_MSG) ctr_d = ctr_q + CTR_W'(1);
          else                  have_d = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      job_q   <= JOB_MSG;
      ctr_q   <= CTR_W'(1);
      have_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      job_q   <= job_d;
      ctr_q   <= ctr_d;
      have_q  <= have_d;
      start_q <= start_d;
    end
  end

  assign start    = start_q;
  assign busy     = (st_q == SQ_WAIT);
  assign tag_job  = (job_q == JOB_TAG);
  assign ctr      = ctr_q;
  assign last_blk = (ctr_q == nblk);
  assign fin_msg  = busy && ciph_done && (job_q == JOB_MSG);
  assign fin_tag  = busy && ciph_done && (job_q == JOB_TAG);
  assign tag_have = have_q;

  // R10: request is a single-cycle pulse
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R3: no new request while one is outstanding
  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ciph_done) |=> !start_q);

  // R6: the counter never runs past one beyond the final block while counting
  a_r6_ctr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_e == CMD_COUNT) |-> (ctr_q <= nblk + CTR_W'(1)));
endmodule

// File: rtl/ccm_ks_top.sv
module ccm_ks_top
  import ccm_ks_pkg::*;
#(
  parameter int LEN_BYTES = 2,
  localparam int CTR_W    = 8 * LEN_BYTES,
  localparam int NONCE_W  = 8 * (15 - LEN_BYTES),
  localparam int KEEP_W   = $clog2(BLK_BYT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cmd,
  input  logic [NONCE_W-1:0] nonce,
  input  logic [CTR_W-1:0]   msg_len,
  input  logic [BLK_W-1:0]   msg_blk,
  output logic               ciph_start,
  output logic [BLK_W-1:0]   ciph_blk,
  input  logic               ciph_done,
  input  logic [BLK_W-1:0]   ciph_res,
  output logic [BLK_W-1:0]   ks_out,
  output logic               ks_out_vld,
  output logic [BLK_W-1:0]   s0_out,
  output logic               s0_vld
);
  logic rst_meta, srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  logic [CTR_W:0]   len_p15;
  logic [CTR_W-1:0] nblk;
  logic [3:0]       rem;

  assign len_p15 = {1'b0, msg_len} + (CTR_W + 1)'(15);
  assign nblk    = {3'b000, len_p15[CTR_W:4]};
  assign rem     = msg_len[3:0];

  logic             busy, tag_job, last_blk, fin_msg, fin_tag, tag_have;
  logic [CTR_W-1:0] ctr, ctr_sel;

  ccm_ks_seq #(.CTR_W(CTR_W)) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .cmd      (cmd),
    .nblk     (nblk),
    .ciph_done(ciph_done),
    .start    (ciph_start),
    .busy     (busy),
    .tag_job  (tag_job),
    .ctr      (ctr),
    .last_blk (last_blk),
    .fin_msg  (fin_msg),
    .fin_tag  (fin_tag),
    .tag_have (tag_have)
  );

  assign ctr_sel = tag_job ? '0 : ctr;

  ccm_ks_ablk #(.LEN_BYTES(LEN_BYTES)) u_ablk (
    .nonce(nonce),
    .ctr  (ctr_sel),
    .blk  (ciph_blk)
  );

  logic [KEEP_W-1:0] keep;
  logic [BLK_W-1:0]  xored, masked;

  assign keep  = (last_blk && (rem != 4'd0)) ? KEEP_W'(rem) : KEEP_W'(BLK_BYT);
  assign xored = ciph_res ^ msg_blk;

  ccm_ks_mask u_mask (
    .din (xored),
    .keep(keep),
    .dout(masked)
  );

  logic [BLK_W-1:0] ks_q, ks_d, s0_q, s0_d;
  logic             vld_q, vld_d;

  always_comb begin
    ks_d  = fin_msg ? masked : ks_q;
    s0_d  = fin_tag ? ciph_res : s0_q;
    vld_d = fin_msg;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ks_q  <= '0;
      s0_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      ks_q  <= ks_d;
      s0_q  <= s0_d;
      vld_q <= vld_d;
    end
  end

  assign ks_out     = ks_q;
  assign ks_out_vld = vld_q;
  assign s0_out     = s0_q;
  assign s0_vld     = tag_have;

  // R4: a data strobe always follows a cipher completion
  a_r4_vld_after_done: assert property (@(posedge clk) disable iff (!srst_n)
    ks_out_vld |-> $past(ciph_done));

  // R7: the tag keystream never coincides with a data strobe
  a_r7_tag_not_data: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(s0_vld) |-> !ks_out_vld);

  // R8: an idle command issues no request on the next cycle
  a_r8_idle_no_req: assert property (@(posedge clk) disable iff (!srst_n)
    !cmd[0] |=> !ciph_start);

  // R10: counter block held steady while the cipher works
  a_r10_blk_stable: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && !ciph_done) |=> $stable(ciph_blk));
endmodule

// File: tb/ccm_ks_top_tb.sv
module ccm_ks_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LB  = 2;
  localparam int CW  = 8 * LB;
  localparam int NW  = 8 * (15 - LB);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cmd;
  logic [NW-1:0] nonce;
  logic [CW-1:0] msg_len;
  logic [127:0]  msg_blk;
  logic          ciph_start;
  logic [127:0]  ciph_blk;
  logic          ciph_done;
  logic [127:0]  ciph_res;
  logic [127:0]  ks_out;
  logic          ks_out_vld;
  logic [127:0]  s0_out;
  logic          s0_vld;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccm_ks_top #(.LEN_BYTES(LB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .nonce(nonce), .msg_len(msg_len),
    .msg_blk(msg_blk), .ciph_start(ciph_start), .ciph_blk(ciph_blk),
    .ciph_done(ciph_done), .ciph_res(ciph_res), .ks_out(ks_out),
    .ks_out_vld(ks_out_vld), .s0_out(s0_out), .s0_vld(s0_vld)
  );

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  logic [127:0] msg_mem [0:7];
  int           chk_mode = 0;
  int           exp_ctr  = 1;
  int           n_start  = 0;
  int           n_out    = 0;
  logic [127:0] last_issue = '0;
  logic         prev_done = 1'b0;

  function automatic logic [127:0] fake_e(input logic [127:0] b);
    return {b[60:0], b[127:61]} ^ 128'h5a3c_96e1_0f7d_b284_c3a1_7e59_2d6b_f048 ^ {b[7:0], 120'h0};
  endfunction

  function automatic logic [127:0] mk_blk(input logic [NW-1:0] n, input int c);
    return {8'(LB - 1), n, CW'(c)};
  endfunction

  function automatic logic [127:0] exp_out(input logic [127:0] blk, input logic [127:0] m,
                                           input int len);
    logic [127:0] v;
    int c, nb, r;
    c  = int'(blk[CW-1:0]);
    nb = (len + 15) / 16;
    r  = len % 16;
    v  = fake_e(blk) ^ m;
    if (c == nb && r != 0)
      for (int k = r; k < 16; k++) v[127 - 8*k -: 8] = 8'h00;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  // cipher model
  initial begin
    ciph_done = 1'b0;
    ciph_res  = '0;
    msg_blk   = '0;
    forever begin
      @(negedge clk);
      if (rst_n && ciph_start) begin
        logic [127:0] b;
        int lat, c;
        b   = ciph_blk;
        lat = int'($urandom_range(0, 3));
        c   = int'(b[CW-1:0]);
        repeat (lat) @(negedge clk);
        @(posedge clk); #1;
        ciph_done = 1'b1;
        ciph_res  = fake_e(b);
        msg_blk   = (c >= 1 && c <= 8) ? msg_mem[c-1] : {4{$urandom()}};
        @(posedge clk); #1;
        ciph_done = 1'b0;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (ciph_start) begin
        n_start++;
        last_issue = ciph_blk;
        check(ciph_blk[127:120] == 8'(LB - 1) && ciph_blk[127-8 -: NW] == nonce,
              "R2", ciph_blk, mk_blk(nonce, int'(ciph_blk[CW-1:0])));
        if (chk_mode == 1) begin
          check(int'(ciph_blk[CW-1:0]) == exp_ctr, "R3", ciph_blk, mk_blk(nonce, exp_ctr));
          exp_ctr++;
        end else if (chk_mode == 2) begin
          check(ciph_blk[CW-1:0] == '0, "R7", ciph_blk, mk_blk(nonce, 0));
        end
      end
      if (ks_out_vld) begin
        logic [127:0] e;
        int c;
        n_out++;
        c = int'(last_issue[CW-1:0]);
        e = exp_out(last_issue, (c >= 1 && c <= 8) ? msg_mem[c-1] : '0, int'(msg_len));
        check(ks_out == e, ((int'(msg_len) % 16 != 0) && c == (int'(msg_len) + 15) / 16)
              ? "R5" : "R4", ks_out, e);
        check(prev_done, "R4", 128'(ks_out_vld), 128'(1));
      end
      prev_done = ciph_done;
    end
  end

  task automatic drive_cmd(input logic [1:0] c);
    @(posedge clk); #1;
    cmd = c;
  endtask

  task automatic run_msg(input int len, input logic [NW-1:0] nv);
    int nb;
    drive_cmd(2'b00);
    repeat (3) @(posedge clk);
    #1;
    nonce   = nv;
    msg_len = CW'(len);
    for (int i = 0; i < 8; i++) msg_mem[i] = {$urandom(), $urandom(), $urandom(), $urandom()};
    nb       = (len + 15) / 16;
    chk_mode = 1;
    exp_ctr  = 1;
    n_start  = 0;
    n_out    = 0;
    drive_cmd(2'b11);
    for (int w = 0; w < 400 && n_out < nb; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(n_out == nb && n_start == nb, "R6", 128'(n_out), 128'(nb));
    chk_mode = 2;
    drive_cmd(2'b01);
    for (int w = 0; w < 50 && !s0_vld; w++) @(negedge clk);
    check(s0_vld && s0_out == fake_e(mk_blk(nv, 0)), "R7", s0_out, fake_e(mk_blk(nv, 0)));
    repeat (8) @(negedge clk);
    check(n_start == nb + 1 && n_out == nb, "R7", 128'(n_start), 128'(nb + 1));
    chk_mode = 0;
    drive_cmd(2'b00);
    repeat (3) @(negedge clk);
    check(!s0_vld, "R8", 128'(s0_vld), 128'(0));
  endtask

  initial begin
    void'($urandom(32'd20240917));
    rst_n   = 1'b0;
    cmd     = 2'b00;
    nonce   = '0;
    msg_len = '0;
    for (int i = 0; i < 8; i++) msg_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!ks_out_vld && !s0_vld && !ciph_start && ks_out == '0 && s0_out == '0,
          "R1", ks_out, '0);

    // directed lengths: empty, single, partial-in-one, exact multiple, odd tail, maximum
    run_msg(0,   {NW{1'b1}});
    run_msg(16,  NW'(104'h0102030405060708090a0b0c0d));
    run_msg(7,   NW'(104'hdeadbeef));
    run_msg(48,  NW'(104'h77));
    run_msg(33,  NW'(104'h1234_5678_9abc));
    run_msg(128, NW'(104'hfeed_face_cafe));

    // R9: command dropped to 2'b10 while the first request is outstanding
    drive_cmd(2'b00);
    repeat (3) @(posedge clk);
    #1;
    msg_len = CW'(48);
    for (int i = 0; i < 8; i++) msg_mem[i] = {$urandom(), $urandom(), $urandom(), $urandom()};
    chk_mode = 1; exp_ctr = 1; n_start = 0; n_out = 0;
    drive_cmd(2'b11);
    for (int w = 0; w < 50 && n_start == 0; w++) @(negedge clk);
    drive_cmd(2'b10);
    for (int w = 0; w < 50 && n_out == 0; w++) @(negedge clk);
    check(n_out == 1, "R9", 128'(n_out), 128'(1));
    repeat (10) @(negedge clk);
    check(n_start == 1, "R8", 128'(n_start), 128'(1));

    // random lengths and nonces
    for (int t = 0; t < 8; t++) begin
      int len;
      logic [NW-1:0] nv;
      len = int'($urandom_range(1, 128));
      nv  = {$urandom(), $urandom(), $urandom(), $urandom()};
      run_msg(len, nv);
    end

    report();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report();
    $finish;
  end
endmodule